// File: doc/BRIEF.md
# Asynchronous Byte-Lane Memory Sequencer

This block sits between a synchronous request port and an external 16-bit static memory that has no clock of its own. A user raises a request with a word address, a read/write flag, a two-bit lane mask and write data. The block then produces the memory's active-low select, write strobe, output strobe and two lane strobes, plus the data-bus direction, in the right order. It acknowledges with a one-cycle pulse. Reads return the captured word together with that pulse.

Every nanosecond limit of the memory is a parameter in picoseconds. Each one becomes a clock-cycle count by ceiling division by the clock period, so the same RTL is safe at any clock rate. Writes end on the rising edge of the write strobe. The output strobe stays high for the whole write, and the block drives the bus only while it writes, so the bus never sees two drivers. After reset the block keeps the select and write strobes high for a power-up interval. It accepts no request until that interval has passed.

Top module: `amem_ctrl`

## Requirements
- R1: After reset release, memCeN and memWeN stay high and no acknowledge is given for PWR = ceil(T_PWRUP_PS / CLK_PS) cycles. A request pending from reset is accepted on clock edge PWR+1.
- R2: A read holds memCeN and memOeN low and memWeN high for RD = ceil(T_ACCESS_PS / CLK_PS) cycles. It captures the bus on the last of those edges and raises reqAck on that same edge. With default timing this is 1+RD edges after acceptance.
- R3: Mask bit 0 selects the lower lane (bits 7:0, strobe memLbN) and mask bit 1 selects the upper lane (bits 15:8, strobe memUbN). A lane whose bit is 0 keeps its strobe high and reads back as zero.
- R4: A write holds memCeN and memWeN low for WP = ceil(T_WPULSE_PS / CLK_PS) cycles with the data driven. It keeps memCeN low and the address and data held for REC = ceil(max(T_RECOVER_PS, T_HIGH_PS) / CLK_PS) cycles after memWeN rises. Only the selected lanes change in memory.
- R5: memOeN stays high whenever memWeN is low. memDqOe is high only during the write pulse and its recovery, and never while memOeN is low.
- R6: memAddr does not change while memCeN stays low.
- R7: A request with mask 00 is acknowledged on the first edge without memCeN going low. It leaves both memory contents and rdData unchanged.
- R8: reqAck is a single-cycle pulse. Two falling edges of memCeN are at least ceil(T_CYCLE_PS / CLK_PS) cycles apart.
- R9: memWeN stays low for at least ceil(15 ns / clock period) cycles in every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; hold until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqMask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| reqWdata | input | 16 | Write data |
| reqAck | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read result, valid with reqAck |
| memAddr | output | ADDR_W | Memory address pins |
| memCeN | output | 1 | Memory select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output strobe, active low |
| memLbN | output | 1 | Lower lane strobe, active low |
| memUbN | output | 1 | Upper lane strobe, active low |
| memDqOut | output | 16 | Data driven toward memory |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 16 | Data returned by memory |

## Verification
The bench targets a request that waits through power-up. A hold counter that is off by one would show up as an acknowledge one cycle early, or as the select strobe falling during the hold. Partial-lane writes sweep all four mask values over addresses that toggle the top address bit. A design that mixed up the lane order, or wrote an unselected byte, would corrupt half-words that are later read back under every mask. Monitors at the pins watch for a bus driven while the output strobe is low, an address that moves inside a select window, short write pulses and select edges spaced too closely. A zero mask must finish in one cycle with no select activity, so a design that still ran a memory cycle for it would show up here.

// File: rtl/amem_pkg.sv
package amem_pkg;

  localparam int LANES = 2;
  localparam int DATA_W = 8 * LANES;

  typedef struct packed {
    logic load;
    logic capture;
    logic ceAct;
    logic weAct;
    logic oeAct;
    logic laneAct;
    logic drive;
  } amem_strobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/amem_ctrl_fsm.sv
module amem_ctrl_fsm
  import amem_pkg::*;
#(
  parameter int CLK_PS       = 20000,
  parameter int T_CYCLE_PS   = 35000,
  parameter int T_ACCESS_PS  = 35000,
  parameter int T_WPULSE_PS  = 18000,
  parameter int T_RECOVER_PS = 12000,
  parameter int T_HIGH_PS    = 2000,
  parameter int T_PWRUP_PS   = 2000000000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic [1:0]   reqMask,
  output logic         reqAck,
  output amem_strobe_t strb
);

  localparam int PWR_CYC  = imax(1, cdiv(T_PWRUP_PS, CLK_PS));
  localparam int RD_CYC   = imax(1, cdiv(T_ACCESS_PS, CLK_PS));
  localparam int WP_CYC   = imax(1, cdiv(T_WPULSE_PS, CLK_PS));
  localparam int HIGH_CYC = imax(1, cdiv(T_HIGH_PS, CLK_PS));
  localparam int REC_CYC  = imax(HIGH_CYC, cdiv(T_RECOVER_PS, CLK_PS));
  localparam int CYC_CYC  = imax(1, cdiv(T_CYCLE_PS, CLK_PS));
  localparam int RD_REST  = imax(HIGH_CYC, CYC_CYC - RD_CYC) - 1;
  localparam int WR_REST  = imax(0, CYC_CYC - WP_CYC - REC_CYC - 1);
  localparam int CNT_MAX  = imax(PWR_CYC, imax(RD_CYC, imax(WP_CYC,
                            imax(REC_CYC, imax(RD_REST, WR_REST)))));
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    S_PWRUP, S_IDLE, S_READ, S_WPULSE, S_WREC, S_REST
  } state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic              ackQ;
  logic              take;
  logic              cntZero;

  assign take    = (st == S_IDLE) && reqValid && !ackQ;
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= S_PWRUP;
      cnt  <= CNT_W'(PWR_CYC - 1);
      ackQ <= 1'b0;
    end else begin
      ackQ <= 1'b0;
      case (st)
        S_PWRUP: begin
          if (cntZero) st <= S_IDLE;
          else         cnt <= cnt - 1'b1;
        end
        S_IDLE: begin
          if (take) begin
            if (reqMask == 2'b00) begin
              ackQ <= 1'b1;
            end else if (reqWrite) begin
              st  <= S_WPULSE;
              cnt <= CNT_W'(WP_CYC - 1);
            end else begin
              st  <= S_READ;
              cnt <= CNT_W'(RD_CYC - 1);
            end
          end
        end
        S_READ: begin
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else if (RD_REST == 0) begin
            st   <= S_IDLE;
            ackQ <= 1'b1;
          end else begin
            st  <= S_REST;
            cnt <= CNT_W'(RD_REST - 1);
          end
        end
        S_WPULSE: begin
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else begin
            st  <= S_WREC;
            cnt <= CNT_W'(REC_CYC - 1);
          end
        end
        S_WREC: begin
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else if (WR_REST == 0) begin
            st   <= S_IDLE;
            ackQ <= 1'b1;
          end else begin
            st  <= S_REST;
            cnt <= CNT_W'(WR_REST - 1);
          end
        end
        S_REST: begin
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else begin
            st   <= S_IDLE;
            ackQ <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.load    = take && (reqMask != 2'b00);
    strb.capture = (st == S_READ) && cntZero;
    strb.ceAct   = (st == S_READ) || (st == S_WPULSE) || (st == S_WREC);
    strb.weAct   = (st == S_WPULSE);
    strb.oeAct   = (st == S_READ);
    strb.laneAct = strb.ceAct;
    strb.drive   = (st == S_WPULSE) || (st == S_WREC);
  end

  assign reqAck = ackQ;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck); // R8

  AST_PWRUP_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_PWRUP) |-> (!ackQ && !strb.load)); // R1

  AST_ZERO_MASK_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (take && reqMask == 2'b00) |=> (reqAck && st == S_IDLE)); // R7

  AST_WRITE_KEEPS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_WPULSE && cntZero) |=> (strb.ceAct && !strb.weAct)); // R4

endmodule

// File: rtl/amem_ctrl_dp.sv
module amem_ctrl_dp
  import amem_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  amem_strobe_t       strb,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [LANES-1:0]   reqMask,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [DATA_W-1:0]  memDqIn,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memCeN,
  output logic               memWeN,
  output logic               memOeN,
  output logic [LANES-1:0]   memLaneN,
  output logic [DATA_W-1:0]  memDqOut,
  output logic               memDqOe,
  output logic [DATA_W-1:0]  rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] capVal;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign capVal[g*8 +: 8] = maskQ[g] ? memDqIn[g*8 +: 8] : 8'h00;
    assign memLaneN[g]      = ~(strb.laneAct & maskQ[g]);

    AST_UNSEL_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (strb.capture && !maskQ[g]) |=> (rdData[g*8 +: 8] == 8'h00)); // R3
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      maskQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        maskQ  <= reqMask;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdQ <= capVal;
    end
  end

  assign memAddr  = addrQ;
  assign memCeN   = ~strb.ceAct;
  assign memWeN   = ~strb.weAct;
  assign memOeN   = ~strb.oeAct;
  assign memDqOut = wdataQ;
  assign memDqOe  = strb.drive;
  assign rdData   = rdQ;

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN); // R5

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && memDqOe)); // R5

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr)); // R6

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R4

endmodule

// File: rtl/amem_ctrl.sv
module amem_ctrl
  import amem_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int CLK_PS       = 20000,
  parameter int T_CYCLE_PS   = 35000,
  parameter int T_ACCESS_PS  = 35000,
  parameter int T_WPULSE_PS  = 18000,
  parameter int T_RECOVER_PS = 12000,
  parameter int T_HIGH_PS    = 2000,
  parameter int T_PWRUP_PS   = 2000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqMask,
  input  logic [15:0]       reqWdata,
  output logic              reqAck,
  output logic [15:0]       rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [15:0]       memDqOut,
  output logic              memDqOe,
  input  logic [15:0]       memDqIn
);

  amem_strobe_t strb;
  logic [LANES-1:0] laneN;

  amem_ctrl_fsm #(
    .CLK_PS      (CLK_PS),
    .T_CYCLE_PS  (T_CYCLE_PS),
    .T_ACCESS_PS (T_ACCESS_PS),
    .T_WPULSE_PS (T_WPULSE_PS),
    .T_RECOVER_PS(T_RECOVER_PS),
    .T_HIGH_PS   (T_HIGH_PS),
    .T_PWRUP_PS  (T_PWRUP_PS)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .reqAck  (reqAck),
    .strb    (strb)
  );

  amem_ctrl_dp #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqMask (reqMask),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memLaneN(laneN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .rdData  (rdData)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

endmodule

// File: tb/tb_amem_ctrl.sv
`timescale 1ns/1ps
module tb_amem_ctrl;

  localparam int CLK_PS  = 20000;
  localparam int PWR_PS  = 2000000;
  localparam int PWR_CYC = (PWR_PS + CLK_PS - 1) / CLK_PS;
  localparam int RD_CYC  = (35000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_CYC  = (18000 + CLK_PS - 1) / CLK_PS;
  localparam int REC_CYC = (12000 + CLK_PS - 1) / CLK_PS;
  localparam int CYC_MIN = (35000 + CLK_PS - 1) / CLK_PS;
  localparam int WE_MIN  = (15000 + CLK_PS - 1) / CLK_PS;
  localparam int RD_LAT  = 1 + RD_CYC;
  localparam int WR_LAT  = 1 + WP_CYC + REC_CYC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [1:0]  reqMask = 2'b00;
  logic [15:0] reqWdata = '0;
  logic        reqAck;
  logic [15:0] rdData;
  logic [16:0] memAddr;
  logic        memCeN, memWeN, memOeN, memLbN, memUbN, memDqOe;
  logic [15:0] memDqOut, memDqIn;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  amem_ctrl #(.CLK_PS(CLK_PS), .T_PWRUP_PS(PWR_PS)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqMask(reqMask), .reqWdata(reqWdata),
    .reqAck(reqAck), .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memLbN(memLbN), .memUbN(memUbN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // memory model: 64 words, index built from address bits 16 and 4:0
  logic [15:0] mem [0:63];
  logic [15:0] expMem [0:31];
  logic [5:0]  idx;
  logic        rdEn;
  int          wrNoDrive = 0;

  assign idx  = {memAddr[16], memAddr[4:0]};
  assign rdEn = !memCeN && !memOeN && memWeN;
  assign memDqIn = {(rdEn && !memUbN) ? mem[idx][15:8] : 8'hA5,
                    (rdEn && !memLbN) ? mem[idx][7:0]  : 8'h5A};

  always @(posedge memWeN) begin
    if (rstN && memCeN === 1'b0) begin
      if (!memDqOe) wrNoDrive++;
      if (!memLbN) mem[idx][7:0]  = memDqOut[7:0];
      if (!memUbN) mem[idx][15:8] = memDqOut[15:8];
    end
  end

  // pin monitors
  int vContend = 0, vOeInWr = 0, vAddrMove = 0, vCeSpace = 0;
  int vWeShort = 0, vPwr = 0, vAckLong = 0;
  int cycSinceRst = 0, sinceCeFall = 1000, weRun = 0, ceLowCnt = 0;
  logic prevCeN = 1'b1, prevAck = 1'b0;
  logic [16:0] prevAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      cycSinceRst++;
      if (memDqOe && !memOeN) vContend++;
      if (!memWeN && !memOeN) vOeInWr++;
      if (!memCeN && !prevCeN && memAddr != prevAddr) vAddrMove++;
      if (cycSinceRst <= PWR_CYC && (!memCeN || !memWeN || reqAck)) vPwr++;
      if (reqAck && prevAck) vAckLong++;
      if (!memCeN && prevCeN) begin
        if (sinceCeFall < CYC_MIN) vCeSpace++;
        sinceCeFall = 0;
      end
      sinceCeFall++;
      if (!memWeN) weRun++;
      else if (weRun > 0) begin
        if (weRun < WE_MIN) vWeShort++;
        weRun = 0;
      end
      if (!memCeN) ceLowCnt++;
      prevCeN  = memCeN;
      prevAddr = memAddr;
      prevAck  = reqAck;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] addrOf(input int k);
    logic [4:0] kk;
    kk = 5'(k);
    return {kk[2], 11'(k * 37), kk};
  endfunction

  function automatic logic [15:0] dataOf(input int k);
    return 16'(k * 16'h0931) ^ 16'hC35A;
  endfunction

  task automatic doReq(input bit wr, input logic [16:0] a, input logic [1:0] m,
                       input logic [15:0] d, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqMask = m; reqWdata = d;
    ceLowCnt = 0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!reqAck && lat < 60);
    reqValid = 1'b0;
  endtask

  initial begin
    #4000000;
    nTests++; nFail++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] e, prevRd;
    logic [1:0] mb;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 32; i++) expMem[i] = 16'h0000;

    // request pending from reset: power-up hold
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = addrOf(0); reqMask = 2'b11;
    repeat (3) @(negedge clk);
    check(memCeN && memWeN && memOeN && !memDqOe && !reqAck, "R1",
          "reset pin state", {memCeN, memWeN, memOeN, memDqOe, reqAck}, 5'b11100);
    rstN = 1'b1;
    lat = 0;
    do begin
      @(posedge clk); lat++; @(negedge clk);
    end while (!reqAck && lat < PWR_CYC + 60);
    reqValid = 1'b0;
    check(lat == PWR_CYC + RD_LAT, "R1", "first ack after power-up", lat, PWR_CYC + RD_LAT);
    check(rdData == 16'h0000, "R2", "first read data", rdData, 0);

    // full-word writes
    for (int k = 0; k < 32; k++) begin
      doReq(1'b1, addrOf(k), 2'b11, dataOf(k), lat);
      expMem[k] = dataOf(k);
      check(lat == WR_LAT, "R4", "write latency", lat, WR_LAT);
    end

    // partial-lane writes, mask k%4 (00 must change nothing)
    for (int k = 0; k < 32; k++) begin
      mb = 2'(k % 4);
      doReq(1'b1, addrOf(k), mb, ~dataOf(k) + 16'(k), lat);
      e = ~dataOf(k) + 16'(k);
      if (mb[0]) expMem[k][7:0]  = e[7:0];
      if (mb[1]) expMem[k][15:8] = e[15:8];
      if (mb == 2'b00) begin
        check(lat == 1, "R7", "zero-mask write latency", lat, 1);
        check(ceLowCnt == 0, "R7", "zero-mask write select activity", ceLowCnt, 0);
      end else begin
        check(lat == WR_LAT, "R4", "lane write latency", lat, WR_LAT);
      end
    end

    // read back under every nonzero mask
    for (int k = 0; k < 32; k++) begin
      for (int m = 1; m < 4; m++) begin
        doReq(1'b0, addrOf(k), 2'(m), 16'h0, lat);
        e = {(m & 2) != 0 ? expMem[k][15:8] : 8'h00,
             (m & 1) != 0 ? expMem[k][7:0]  : 8'h00};
        check(rdData == e, "R3", "lane read data", rdData, e);
        check(lat == RD_LAT, "R2", "read latency", lat, RD_LAT);
      end
    end

    // zero-mask read keeps rdData
    prevRd = rdData;
    doReq(1'b0, addrOf(5), 2'b00, 16'h0, lat);
    check(lat == 1, "R7", "zero-mask read latency", lat, 1);
    check(rdData == prevRd, "R7", "zero-mask read data held", rdData, prevRd);
    check(ceLowCnt == 0, "R7", "zero-mask read select activity", ceLowCnt, 0);

    repeat (4) @(negedge clk);
    check(vPwr == 0, "R1", "activity during power-up", vPwr, 0);
    check(vContend == 0, "R5", "bus driven with output strobe low", vContend, 0);
    check(vOeInWr == 0, "R5", "output strobe low during write", vOeInWr, 0);
    check(wrNoDrive == 0, "R4", "write edge without driven data", wrNoDrive, 0);
    check(vAddrMove == 0, "R6", "address moved under select", vAddrMove, 0);
    check(vCeSpace == 0, "R8", "select edges too close", vCeSpace, 0);
    check(vAckLong == 0, "R8", "acknowledge longer than one cycle", vAckLong, 0);
    check(vWeShort == 0, "R9", "short write pulse", vWeShort, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule